// File: doc/BRIEF.md
# DRAM Row-Strobe Hold Controller

This block drives the row strobe (RAS) and column strobe (CAS) of a simple DRAM port on an external bus that several masters share. Each bus cycle comes in on a request port. The request carries a space type, a row address, a master identity and a DMA single-address flag. For each DRAM cycle the block chooses one of two forms. A full access opens a new row. A burst access reuses the row that is already open and runs only the column state.

Between DRAM cycles the row can be kept open with RAS low, including across accesses to ordinary memory or to internal registers. The row can also be closed. When an open row cannot serve the next DRAM cycle, the block inserts one precharge state that drives RAS high, and then opens the new row. A DMA acknowledge strobe marks single-address DMA transfers. Its width depends on whether DMA burst is allowed. A ready output tells the requester when a new cycle can be accepted.

Top module: `ras_hold_ctrl`

## Requirements
- R1: After reset, RAS and CAS are high (inactive), the DMA acknowledge is low, ready is high and no row is open. The first DRAM cycle is therefore a full access.
- R2: A full access has two states, each lasting one clock. The activate state has RAS low and CAS high. The column state has RAS low and CAS low. Ready is low in both. CAS is never low while RAS is high.
- R3: When burst enable and hold enable are both 1, RAS stays low with ready high after a DRAM cycle ends. A cycle to normal space (req_space 2'b00) or internal-register space (2'b10) lasts one busy state with RAS still low, and the row is still open afterwards.
- R4: When burst enable is 0, or hold enable is 0, RAS returns high once the column state ends. Every DRAM cycle is then a full access, and a non-DRAM cycle leaves RAS high.
- R5: A DRAM cycle (req_space 2'b01) is a burst access when a row is open, its row equals the open row, and burst is permitted. A burst access goes straight to the column state in the first cycle after acceptance.
- R6: A DRAM cycle that meets an open row but cannot burst gets exactly one precharge state first. That state has RAS high and ready low. The activate and column states follow. The new row then becomes the open row.
- R7: When hold enable or burst enable drops while a row is held, RAS goes high in the same cycle and the open row is discarded. The next DRAM cycle begins with activate and no precharge.
- R8: A DMA single-address transfer (req_dma=1, req_single=1) may burst only when dma_burst_en and burst enable are both 1. Otherwise it runs a full access with a fresh row cycle.
- R9: dma_burst_en has no effect on CPU cycles (req_dma=0) or on DMA dual-address cycles (req_single=0). Those follow the rule in R5.
- R10: The DMA acknowledge is high only for DMA single-address transfers. With dma_burst_en=0 it covers both the activate and column states. With dma_burst_en=1 it covers only the column state.
- R11: Ready is low in the precharge, activate, column and non-DRAM busy states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; taken on a clock edge where ready_o is high |
| req_space_i | input | 2 | 00 normal, 01 DRAM, 10 internal register, 11 treated as normal |
| req_row_i | input | ROW_W | Row address of the request |
| req_dma_i | input | 1 | 1 = DMA master, 0 = CPU |
| req_single_i | input | 1 | 1 = DMA single-address transfer |
| burst_en_i | input | 1 | Burst (same-row) accesses allowed |
| hold_en_i | input | 1 | Keep row open between DRAM cycles (needs burst_en_i) |
| dma_burst_en_i | input | 1 | Let DMA single-address transfers burst; narrows acknowledge |
| ready_o | output | 1 | Block can accept a request |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| dack_o | output | 1 | DMA acknowledge, active high |

## Verification
The bench applies a request at a falling edge and removes it at the next falling edge. The rising edge in between accepts it, so the first state after acceptance is visible at that second falling edge. Each later state is visible one falling edge after the one before. The strobe values for each state are checked at exactly those points: activate and column for a full access, column alone for a burst, and precharge one cycle before activate. When hold enable is dropped, RAS follows combinationally. The bench samples it 1 ns after the change, in the same cycle, and samples the idle state at the next falling edge.

// File: rtl/ras_hold_pkg.sv
package ras_hold_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HELD = 3'd1,
    ST_PRE  = 3'd2,
    ST_ACT  = 3'd3,
    ST_COL  = 3'd4,
    ST_EXT  = 3'd5
  } seq_st_e;

  typedef enum logic [1:0] {
    SP_NORMAL = 2'b00,
    SP_DRAM   = 2'b01,
    SP_IOREG  = 2'b10,
    SP_RSVD   = 2'b11
  } space_e;

  typedef struct packed {
    logic is_dram;
    logic is_dma_sgl;
    logic burst_ok;
    logic row_hit;
  } req_attr_t;

endpackage

// File: rtl/ras_burst_dec.sv
module ras_burst_dec
  import ras_hold_pkg::*;
#(
  parameter int unsigned ROW_W = 12
) (
  input  logic [1:0]       space_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             dma_i,
  input  logic             single_i,
  input  logic             burst_en_i,
  input  logic             dma_burst_en_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic             row_open_i,
  output req_attr_t        attr_o
);

  space_e space;

  always_comb begin
    space             = space_e'(space_i);
    attr_o.is_dram    = (space == SP_DRAM);
    attr_o.is_dma_sgl = dma_i & single_i;
    // single-address DMA has its own permission; all others use burst enable
    attr_o.burst_ok   = attr_o.is_dma_sgl ? (burst_en_i & dma_burst_en_i) : burst_en_i;
    attr_o.row_hit    = row_open_i && (row_i == open_row_i);
  end

endmodule

// File: rtl/ras_seq.sv
module ras_seq
  import ras_hold_pkg::*;
#(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  req_attr_t        attr_i,
  input  logic             burst_en_i,
  input  logic             hold_en_i,
  input  logic             dma_burst_en_i,
  output seq_st_e          state_o,
  output logic             hold_q_o,
  output logic             dack_sgl_q_o,
  output logic             dack_col_only_q_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             row_open_o,
  output logic             down_eff_o,
  output logic             ready_o
);

  seq_st_e          state_q, state_d;
  logic             hold_q, hold_d;
  logic             dsgl_q, dcol_q;
  logic [ROW_W-1:0] row_q;
  logic             down_eff, accept, take_burst;

  assign down_eff   = burst_en_i & hold_en_i;
  assign ready_o    = (state_q == ST_IDLE) || (state_q == ST_HELD && down_eff);
  assign accept     = req_valid_i & ready_o;
  assign take_burst = attr_i.is_dram & attr_i.burst_ok & attr_i.row_hit;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = attr_i.is_dram ? ST_ACT : ST_EXT;
        hold_d  = 1'b0;
      end
      ST_HELD: begin
        if (!down_eff) begin
          state_d = ST_IDLE;
        end else if (accept) begin
          if (!attr_i.is_dram) begin
            state_d = ST_EXT;
            hold_d  = 1'b1;
          end else if (take_burst) begin
            state_d = ST_COL;
          end else begin
            state_d = ST_PRE;
          end
        end
      end
      ST_PRE:  state_d = ST_ACT;
      ST_ACT:  state_d = ST_COL;
      ST_COL:  state_d = down_eff ? ST_HELD : ST_IDLE;
      ST_EXT:  state_d = (hold_q && down_eff) ? ST_HELD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
      dsgl_q  <= 1'b0;
      dcol_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      if (accept && attr_i.is_dram) begin
        row_q  <= req_row_i;
        dsgl_q <= attr_i.is_dma_sgl;
        dcol_q <= dma_burst_en_i;
      end
    end
  end

  assign state_o           = state_q;
  assign hold_q_o          = hold_q;
  assign dack_sgl_q_o      = dsgl_q;
  assign dack_col_only_q_o = dcol_q;
  assign open_row_o        = row_q;
  assign row_open_o        = (state_q == ST_HELD) || (state_q == ST_EXT && hold_q);
  assign down_eff_o        = down_eff;

  p_act_to_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ACT |=> state_q == ST_COL);
  p_pre_to_act_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PRE |=> state_q == ST_ACT);
  p_burst_direct_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && accept && take_burst) |=> state_q == ST_COL);
  p_drop_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && !down_eff) |=> state_q == ST_IDLE);
  p_busy_not_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_PRE, ST_ACT, ST_COL, ST_EXT}) |-> !ready_o);

endmodule

// File: rtl/ras_strobe_gen.sv
module ras_strobe_gen
  import ras_hold_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  seq_st_e state_i,
  input  logic    hold_q_i,
  input  logic    down_eff_i,
  input  logic    dack_sgl_q_i,
  input  logic    dack_col_only_q_i,
  output logic    ras_n_o,
  output logic    cas_n_o,
  output logic    dack_o
);

  logic ras_low, cas_low;

  always_comb begin
    ras_low = (state_i == ST_ACT) || (state_i == ST_COL) ||
              (state_i == ST_HELD && down_eff_i) ||
              (state_i == ST_EXT && hold_q_i && down_eff_i);
    cas_low = (state_i == ST_COL);
    dack_o  = dack_sgl_q_i &&
              ((state_i == ST_COL) || (state_i == ST_ACT && !dack_col_only_q_i));
  end

  assign ras_n_o = ~ras_low;
  assign cas_n_o = ~cas_low;

  p_cas_under_ras_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o);
  p_dack_in_ras_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> !ras_n_o);
  p_pre_ras_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_PRE |-> (ras_n_o && cas_n_o && !dack_o));

endmodule

// File: rtl/ras_hold_ctrl.sv
module ras_hold_ctrl
  import ras_hold_pkg::*;
#(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_space_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic             req_dma_i,
  input  logic             req_single_i,
  input  logic             burst_en_i,
  input  logic             hold_en_i,
  input  logic             dma_burst_en_i,
  output logic             ready_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             dack_o
);

  req_attr_t        attr;
  seq_st_e          state;
  logic             hold_q, dsgl_q, dcol_q, row_open, down_eff;
  logic [ROW_W-1:0] open_row;

  ras_burst_dec #(.ROW_W(ROW_W)) u_dec (
    .space_i        (req_space_i),
    .row_i          (req_row_i),
    .dma_i          (req_dma_i),
    .single_i       (req_single_i),
    .burst_en_i     (burst_en_i),
    .dma_burst_en_i (dma_burst_en_i),
    .open_row_i     (open_row),
    .row_open_i     (row_open),
    .attr_o         (attr)
  );

  ras_seq #(.ROW_W(ROW_W)) u_seq (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .req_valid_i       (req_valid_i),
    .req_row_i         (req_row_i),
    .attr_i            (attr),
    .burst_en_i        (burst_en_i),
    .hold_en_i         (hold_en_i),
    .dma_burst_en_i    (dma_burst_en_i),
    .state_o           (state),
    .hold_q_o          (hold_q),
    .dack_sgl_q_o      (dsgl_q),
    .dack_col_only_q_o (dcol_q),
    .open_row_o        (open_row),
    .row_open_o        (row_open),
    .down_eff_o        (down_eff),
    .ready_o           (ready_o)
  );

  ras_strobe_gen u_strb (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .state_i           (state),
    .hold_q_i          (hold_q),
    .down_eff_i        (down_eff),
    .dack_sgl_q_i      (dsgl_q),
    .dack_col_only_q_i (dcol_q),
    .ras_n_o           (ras_n_o),
    .cas_n_o           (cas_n_o),
    .dack_o            (dack_o)
  );

  p_dack_sgl_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i && !(req_dma_i && req_single_i)) |=> !dack_o);

endmodule

// File: tb/sim_ras_hold_ctrl.sv
module sim_ras_hold_ctrl;

  localparam int ROW_W = 12;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_space = 2'b00;
  logic [ROW_W-1:0] req_row = '0;
  logic             req_dma = 1'b0;
  logic             req_single = 1'b0;
  logic             burst_en = 1'b0;
  logic             hold_en = 1'b0;
  logic             dma_burst_en = 1'b0;
  logic             ready, ras_n, cas_n, dack;
  int               checks = 0;
  int               errors = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  ras_hold_ctrl #(.ROW_W(ROW_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_space_i(req_space),
    .req_row_i(req_row), .req_dma_i(req_dma), .req_single_i(req_single),
    .burst_en_i(burst_en), .hold_en_i(hold_en), .dma_burst_en_i(dma_burst_en),
    .ready_o(ready), .ras_n_o(ras_n), .cas_n_o(cas_n), .dack_o(dack)
  );

  // expected: ras_n cas_n dack ready
  task automatic chk(input logic e_ras, input logic e_cas, input logic e_dack,
                     input logic e_rdy, input string tag);
    checks++;
    if ({ras_n, cas_n, dack, ready} !== {e_ras, e_cas, e_dack, e_rdy}) begin
      errors++;
      $display("FAIL %s: ras_n/cas_n/dack/ready actual %b%b%b%b expected %b%b%b%b",
               tag, ras_n, cas_n, dack, ready, e_ras, e_cas, e_dack, e_rdy);
    end
  endtask

  task automatic do_reset(input logic be, input logic he, input logic db);
    @(negedge clk);
    rst_ni = 1'b0; req_valid = 1'b0;
    burst_en = be; hold_en = he; dma_burst_en = db;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // returns at the falling edge where the first post-accept state shows
  task automatic issue(input logic [1:0] sp, input int row, input logic dma, input logic sgl);
    @(negedge clk);
    req_space = sp; req_row = ROW_W'(row); req_dma = dma; req_single = sgl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic open_row(input int row);
    issue(2'b01, row, 1'b0, 1'b0); step(); step();
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b1, 1'b0);
    chk(1, 1, 0, 1, "R1 reset state");
    issue(2'b01, 5, 1'b0, 1'b0);
    chk(0, 1, 0, 0, "R1 first access activates");
  endtask

  task automatic t_full_up();
    do_reset(1'b1, 1'b0, 1'b0);
    issue(2'b01, 5, 1'b0, 1'b0);
    chk(0, 1, 0, 0, "R2 activate state");
    step(); chk(0, 0, 0, 0, "R2 column state");
    step(); chk(1, 1, 0, 1, "R4 up mode releases");
    issue(2'b01, 5, 1'b0, 1'b0);
    chk(0, 1, 0, 0, "R4 same row still full");
    step(); step();
    issue(2'b00, 5, 1'b0, 1'b0);
    chk(1, 1, 0, 0, "R11 R4 normal space busy, ras high");
    step(); chk(1, 1, 0, 1, "R4 back to idle");
    do_reset(1'b0, 1'b1, 1'b0);
    open_row(3);
    chk(1, 1, 0, 1, "R4 burst_en 0 overrides hold");
  endtask

  task automatic t_hold();
    do_reset(1'b1, 1'b1, 1'b0);
    open_row(7);
    chk(0, 1, 0, 1, "R3 row held after access");
    issue(2'b00, 0, 1'b0, 1'b0);
    chk(0, 1, 0, 0, "R3 normal access keeps ras low");
    step(); chk(0, 1, 0, 1, "R3 held after normal");
    issue(2'b10, 0, 1'b0, 1'b0);
    chk(0, 1, 0, 0, "R3 ioreg access keeps ras low");
    step(); chk(0, 1, 0, 1, "R3 held after ioreg");
    issue(2'b01, 7, 1'b0, 1'b0);
    chk(0, 0, 0, 0, "R5 burst goes to column");
    step(); chk(0, 1, 0, 1, "R5 held after burst");
  endtask

  task automatic t_row_miss();
    do_reset(1'b1, 1'b1, 1'b0);
    open_row(3);
    issue(2'b01, 4, 1'b0, 1'b0);
    chk(1, 1, 0, 0, "R6 precharge state");
    step(); chk(0, 1, 0, 0, "R6 activate after precharge");
    step(); chk(0, 0, 0, 0, "R6 column");
    step(); chk(0, 1, 0, 1, "R6 held new row");
    issue(2'b01, 4, 1'b0, 1'b0);
    chk(0, 0, 0, 0, "R6 new row latched, bursts");
  endtask

  task automatic t_mode_clear();
    do_reset(1'b1, 1'b1, 1'b0);
    open_row(9);
    hold_en = 1'b0;
    #1 chk(1, 1, 0, 0, "R7 ras high same cycle");
    step(); chk(1, 1, 0, 1, "R7 idle");
    hold_en = 1'b1;
    issue(2'b01, 9, 1'b0, 1'b0);
    chk(0, 1, 0, 0, "R7 reopens with activate");
    step(); step();
    burst_en = 1'b0;
    #1 chk(1, 1, 0, 0, "R7 burst_en drop releases");
    burst_en = 1'b1;
  endtask

  task automatic t_dma_single();
    do_reset(1'b1, 1'b1, 1'b0);
    open_row(2);
    issue(2'b01, 2, 1'b1, 1'b1);
    chk(1, 1, 0, 0, "R8 dma single no burst: precharge");
    step(); chk(0, 1, 1, 0, "R10 dack in activate");
    step(); chk(0, 0, 1, 0, "R10 dack in column");
    step(); chk(0, 1, 0, 1, "R10 dack ends");
    dma_burst_en = 1'b1;
    issue(2'b01, 2, 1'b1, 1'b1);
    chk(0, 0, 1, 0, "R8 dma single bursts, R10 dack column");
    step(); chk(0, 1, 0, 1, "R8 held after dma burst");
    do_reset(1'b1, 1'b1, 1'b1);
    issue(2'b01, 2, 1'b1, 1'b1);
    chk(0, 1, 0, 0, "R10 narrow dack absent in activate");
    step(); chk(0, 0, 1, 0, "R10 narrow dack in column");
  endtask

  task automatic t_dma_dual_cpu();
    do_reset(1'b1, 1'b1, 1'b0);
    open_row(6);
    issue(2'b01, 6, 1'b1, 1'b0);
    chk(0, 0, 0, 0, "R9 dual dma bursts, R10 no dack");
    step();
    issue(2'b01, 6, 1'b0, 1'b1);
    chk(0, 0, 0, 0, "R9 cpu bursts with dma_burst_en 0");
    step();
    dma_burst_en = 1'b1;
    issue(2'b01, 8, 1'b0, 1'b0);
    chk(1, 1, 0, 0, "R9 cpu miss precharges with dma_burst_en 1");
  endtask

  initial begin
    t_reset();
    t_full_up();
    t_hold();
    t_row_miss();
    t_mode_clear();
    t_dma_single();
    t_dma_dual_cpu();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule